// File: doc/BRIEF.md
# Periodic Tick Down-Counter Timer

This block is a periodic tick source for a processor subsystem. A 24-bit counter steps down by one on each qualified clock cycle; once it sits at zero, the next qualified cycle loads it from a reload register. Each such wrap sets a sticky flag and, when enabled, sends out a single-cycle interrupt pulse. To get one tick every N counts, software programs a reload value of N-1.

Software reaches the block through a one-cycle register bus with three word registers. The control/status register sits at offset 0x0, the reload register at 0x4 and the current count at 0x8. A count step is qualified in one of two ways. With clock-select set, every cycle qualifies. With clock-select clear, only cycles where the external reference strobe is high qualify. Software can stop the counter, read out what remains, reprogram the reload value and restart, all at any time.

Top module: `sysTickTimer`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: When enabled, the count drops by one on each cycle where control bit 2 (clock-select) is 1, or where the reference strobe is high while bit 2 is 0.
- R3: A qualified step taken at count zero loads the reload value, so the wrap period is reload+1 steps. Each wrap sets the sticky flag at bit 16 of the control/status register.
- R4: Each wrap gives exactly one high cycle on the interrupt output if control bit 1 is set, and none if bit 1 is clear. The output is never high on two cycles in a row.
- R5: Any write to offset 0x8 forces the count to zero, whatever the data, and clears the sticky flag.
- R6: A read of offset 0x0 returns the flag in bit 16 and clears it, so the next read returns bit 16 as zero. If a wrap happens in the same cycle as the read, the wrap wins.
- R7: Control bits 0 (enable), 1 and 2 read back as written. All other bits read zero. A write to offset 0x0 leaves the sticky flag unchanged.
- R8: While control bit 0 is clear, the count holds its value.
- R9: The reload register keeps only the low 24 bits of a write, and its upper 8 bits read as zero.
- R10: With a reload value of zero the count stays at zero, and neither the flag nor the interrupt is produced.
- R11: Read data appears on the cycle after the request. An address other than 0x0, 0x4 or 0x8 reads zero, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | External reference strobe that qualifies steps when clock-select is 0 |
| busValid | input | 1 | Bus request for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered, valid the cycle after the request |
| tickIrq | output | 1 | One-cycle pulse per wrap |

## Verification
A read issued at clock edge E returns the register value from before E, on the cycle that follows E. The bench notes each read at the edge that takes it and compares the result at the next falling edge. The count, the flag and the interrupt register all update on the edge of the wrap step, so the interrupt is visible one cycle after the zero-count cycle. Expected counts come from the number of qualified edges between the enabling write and the disabling write, with the disabling edge itself counted. The count is always frozen before it is read, and pulse spacing is measured against the wrap period.

// File: rtl/sysTickPkg.sv
package sysTickPkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int CNT_W    = 24;
  localparam int FLAG_BIT = 16;

  typedef struct packed {
    logic wrReload;
    logic clrCount;
    logic stepEn;
  } tickStrobe_t;
endpackage

// File: rtl/sysTickData.sv
module sysTickData
  import sysTickPkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  tickStrobe_t   strb,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] count,
  output logic [CW-1:0] reloadVal,
  output logic          wrapEvt
);
  logic atZero;

  assign atZero  = (count == '0);
  assign wrapEvt = strb.stepEn && atZero && (reloadVal != '0) && !strb.clrCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.clrCount) begin
      count <= '0;
    end else if (strb.stepEn) begin
      if (atZero) count <= reloadVal;
      else        count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              reloadVal <= '0;
    else if (strb.wrReload) reloadVal <= wdata;
  end

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stepEn && !strb.clrCount) |=> $stable(count)); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCount |=> (count == '0)); // R5
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepEn && !atZero && !strb.clrCount) |=> (count == $past(count) - 1'b1)); // R2
  AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> (count == $past(reloadVal))); // R3
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reloadVal == '0 && atZero && !strb.wrReload) |=> (count == '0)); // R10
endmodule

// File: rtl/sysTickCtrl.sv
module sysTickCtrl
  import sysTickPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W,
  parameter int FB = FLAG_BIT
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refTick,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic [CW-1:0] curCount,
  input  logic [CW-1:0] reloadVal,
  input  logic          wrapEvt,
  output tickStrobe_t   strb,
  output logic [DW-1:0] busRdata,
  output logic          tickIrq
);
  localparam logic [AW-1:0] OFF_CTRL = AW'(0);
  localparam logic [AW-1:0] OFF_RLD  = AW'(4);
  localparam logic [AW-1:0] OFF_CUR  = AW'(8);

  logic enable, intEn, clkSel, cntFlag;
  logic selCtrl, selRld, selCur;
  logic wrCtrl, rdCtrl, rdAny;
  logic [DW-1:0] ctrlWord, rdMux;

  assign selCtrl = (busAddr == OFF_CTRL);
  assign selRld  = (busAddr == OFF_RLD);
  assign selCur  = (busAddr == OFF_CUR);
  assign wrCtrl  = busValid && busWrite && selCtrl;
  assign rdCtrl  = busValid && !busWrite && selCtrl;
  assign rdAny   = busValid && !busWrite;

  assign strb.wrReload = busValid && busWrite && selRld;
  assign strb.clrCount = busValid && busWrite && selCur;
  assign strb.stepEn   = enable && (clkSel || refTick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      intEn  <= 1'b0;
      clkSel <= 1'b0;
    end else if (wrCtrl) begin
      enable <= busWdata[0];
      intEn  <= busWdata[1];
      clkSel <= busWdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               cntFlag <= 1'b0;
    else if (strb.clrCount)  cntFlag <= 1'b0;
    else if (wrapEvt)        cntFlag <= 1'b1;
    else if (rdCtrl)         cntFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) tickIrq <= 1'b0;
    else       tickIrq <= wrapEvt && intEn;
  end

  always_comb begin
    ctrlWord     = '0;
    ctrlWord[0]  = enable;
    ctrlWord[1]  = intEn;
    ctrlWord[2]  = clkSel;
    ctrlWord[FB] = cntFlag;
  end

  always_comb begin
    rdMux = '0;
    if (selCtrl)     rdMux = ctrlWord;
    else if (selRld) rdMux = DW'(reloadVal);
    else if (selCur) rdMux = DW'(curCount);
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdata <= '0;
    else if (rdAny) busRdata <= rdMux;
  end

  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> cntFlag); // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |=> !tickIrq); // R4
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |-> cntFlag); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdCtrl && !wrapEvt) |=> !cntFlag); // R6
  AST_CUR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCount |=> !cntFlag); // R5
  AST_CTRL_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && cntFlag) |=> cntFlag); // R7
endmodule

// File: rtl/sysTickTimer.sv
module sysTickTimer
  import sysTickPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refTick,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          tickIrq
);
  tickStrobe_t   strb;
  logic [CW-1:0] curCount, reloadVal;
  logic          wrapEvt;

  sysTickCtrl #(.DW(DW), .AW(AW), .CW(CW), .FB(FLAG_BIT)) uCtrl (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .curCount(curCount), .reloadVal(reloadVal), .wrapEvt(wrapEvt),
    .strb(strb), .busRdata(busRdata), .tickIrq(tickIrq)
  );

  sysTickData #(.CW(CW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata[CW-1:0]),
    .count(curCount), .reloadVal(reloadVal), .wrapEvt(wrapEvt)
  );
endmodule

// File: tb/tb_sysTickTimer.sv
module tb_sysTickTimer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickIrq;

  int nChk = 0;
  int nFail = 0;
  int irqCnt = 0;
  int irqDouble = 0;
  int cycleCnt = 0;
  bit done = 0;
  logic irqPrev = 1'b0;
  logic pendRd = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  int          pulseQ[$];

  sysTickTimer dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .tickIrq(tickIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: reads taken at an edge are compared at the next falling edge
  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    pendRd   <= busValid && !busWrite && rstN;
  end

  always @(negedge clk) begin
    if (pendRd) begin
      if (expQ.size() == 0) begin
        check(busRdata, 32'hFFFF_FFFF, "unexpected read");
      end else begin
        check(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
    if (rstN) begin
      if (tickIrq) begin
        irqCnt++;
        pulseQ.push_back(cycleCnt);
        if (irqPrev) irqDouble++;
      end
      irqPrev = tickIrq;
    end
  end

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
  endtask

  task automatic busRd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a; busWdata = '0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busValid = 1'b0; busWrite = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({31'b0, tickIrq}, 32'h0, "R1 irq after reset");
    busRd(4'h0, 32'h0, "R1 ctrl reset");
    busRd(4'h4, 32'h0, "R1 reload reset");
    busRd(4'h8, 32'h0, "R1 count reset");

    // R9 upper reload bits dropped
    busWr(4'h4, 32'hFF00_0010);
    busRd(4'h4, 32'h0000_0010, "R9 reload upper bits");
    busWr(4'h8, 32'h0000_DEAD);
    busRd(4'h8, 32'h0, "R5 count forced zero");

    // R2 R3 R8 R6: six steps: load 16 then five decrements
    base = irqCnt;
    busWr(4'h0, 32'h5);
    idle(5);
    busWr(4'h0, 32'h4);
    busRd(4'h8, 32'd11, "R2 count after six steps");
    idle(3);
    busRd(4'h8, 32'd11, "R8 count frozen");
    busRd(4'h0, 32'h0001_0004, "R3 flag after wrap");
    busRd(4'h0, 32'h0000_0004, "R6 flag cleared by read");
    idle(2);
    check(irqCnt - base, 0, "R4 no pulse with interrupt disabled");

    // R3 R4 period reload+1 with interrupt
    busWr(4'h8, 32'h0);
    busWr(4'h4, 32'd3);
    base = irqCnt;
    pulseQ.delete();
    busWr(4'h0, 32'h7);
    idle(39);
    busWr(4'h0, 32'h0);
    idle(2);
    check(irqCnt - base, 10, "R4 pulse count over 40 steps");
    for (int i = 1; i < pulseQ.size(); i++)
      check(pulseQ[i] - pulseQ[i-1], 4, "R3 wrap period reload+1");
    busRd(4'h8, 32'h0, "R3 count at end of period");
    busRd(4'h0, 32'h0001_0000, "R3 flag after periodic run");

    // R2 reference strobe qualifies steps
    busWr(4'h4, 32'h100);
    busWr(4'h8, 32'h0);
    busWr(4'h0, 32'h1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      busValid = 1'b0; busWrite = 1'b0;
      refTick = (i % 2 == 0);
    end
    @(negedge clk);
    refTick = 1'b0;
    busValid = 1'b1; busWrite = 1'b1; busAddr = 4'h0; busWdata = 32'h0;
    busRd(4'h8, 32'h0000_00FD, "R2 four strobe steps");
    busWr(4'h8, 32'h123);
    busRd(4'h8, 32'h0, "R5 count zero after write");
    busRd(4'h0, 32'h0, "R5 flag cleared by count write");

    // R10 reload zero
    busWr(4'h4, 32'h0);
    busWr(4'h8, 32'h0);
    base = irqCnt;
    busWr(4'h0, 32'h7);
    idle(10);
    busRd(4'h0, 32'h7, "R10 no flag with zero reload");
    busRd(4'h8, 32'h0, "R10 count held at zero");
    busWr(4'h0, 32'h0);
    idle(2);
    check(irqCnt - base, 0, "R10 no pulses with zero reload");

    // R7 control bits and flag preservation
    busWr(4'h0, 32'hFFFF_FFFF);
    busRd(4'h0, 32'h7, "R7 only control bits stored");
    busWr(4'h0, 32'h0);
    busWr(4'h4, 32'd2);
    busWr(4'h8, 32'h0);
    busWr(4'h0, 32'h5);
    idle(2);
    busWr(4'h0, 32'h4);
    busRd(4'h0, 32'h0001_0004, "R7 flag kept across control write");

    // R11 unmapped address
    busRd(4'hC, 32'h0, "R11 unmapped read");
    busWr(4'hC, 32'h55);
    busRd(4'h4, 32'd2, "R11 unmapped write ignored");
    idle(3);

    check(irqDouble, 0, "R4 never high two cycles");
    check(expQ.size(), 0, "R11 all reads returned");
    done = 1;
    summary();
    $finish;
  end
endmodule